// File: doc/BRIEF.md
# Pulse Generator Configuration Register Bank

This block is an APB completer that stores the settings of a programmable pulse-width generator. Software reaches four word-aligned registers: a cycle-count period, a cycle-count high time, an 8-bit burst size and a single enable bit. The stored values leave the block continuously as parallel outputs, so the waveform logic can use them without any bus traffic.

Every transfer uses the usual two-cycle APB exchange: a setup cycle, then one access cycle. The block never adds wait states. An address that matches none of the four registers completes with an error response. A write to such an address changes nothing, and a read from it returns zero. Writes to narrow registers drop the bits above the register width, and reads of those registers return zero in the unused upper bits.

Top module: `pwm_cfg_regs`

## Requirements
- R1: While rst_ni is low, period_o, pulse_o, size_o and enable_o are all zero. After reset, every register reads back as zero.
- R2: Offset 0x00 holds the 32-bit period. A write there updates period_o at the clock edge that ends the access cycle, and a read returns the stored value.
- R3: Offset 0x04 holds the 32-bit pulse high time. A write updates pulse_o at the edge that ends the access cycle, and a read returns the stored value.
- R4: Offset 0x08 holds the 8-bit size, taken from pwdata_i[7:0]. Write-data bits 31:8 are dropped, and a read returns zero in prdata_o[31:8].
- R5: Offset 0x0C holds the enable, taken from pwdata_i[0], where 1 means on. A read returns the bit in prdata_o[0] and zero in every other bit.
- R6: A register changes only in a cycle where psel_i, penable_i and pwrite_i are all high. A setup cycle with penable_i low changes nothing. A cycle with penable_i high and psel_i low also changes nothing.
- R7: pready_o is high in every access cycle (psel_i and penable_i both high) and low when penable_i is low.
- R8: An access to any address other than 0x00, 0x04, 0x08 or 0x0C raises pslverr_o for the access cycle. This covers a nonzero paddr_i[1:0] and any nonzero bit of paddr_i above bit 3. Such a write changes no register, and such a read returns zero.
- R9: prdata_o is zero in every cycle that is not a read access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| paddr_i | input | ADDR_W (8) | Byte address |
| psel_i | input | 1 | Completer select |
| penable_i | input | 1 | Access-cycle marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| pwdata_i | input | DATA_W (32) | Write data |
| pready_o | output | 1 | Transfer complete |
| prdata_o | output | DATA_W (32) | Read data |
| pslverr_o | output | 1 | Error response for unmapped address |
| period_o | output | PERIOD_W (32) | Stored period in clock cycles |
| pulse_o | output | PULSE_W (32) | Stored high time in clock cycles |
| size_o | output | SIZE_W (8) | Stored burst size |
| enable_o | output | 1 | Stored enable |

## Verification
The bound checker watches the following on every cycle:
- each mapped write reaches its output one edge later;
- outputs stay stable without a write access;
- unmapped accesses raise the error and leave storage untouched;
- pready_o tracks the access cycle;
- prdata_o stays zero outside read accesses.

Some behaviour is only visible through the bench's scenarios:
- the exact readback values, including the zeroed upper bits of the narrow registers;
- the result of a sequence of mixed and error transfers, such as a good value surviving two rejected writes;
- the effect of a reset that arrives partway through a run.

// File: rtl/pwm_cfg_pkg.sv
package pwm_cfg_pkg;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned IDX_W    = 2;

  typedef enum logic [IDX_W-1:0] {
    REG_PERIOD = 2'd0,
    REG_PULSE  = 2'd1,
    REG_SIZE   = 2'd2,
    REG_ENABLE = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/apb_addr_dec.sv
module apb_addr_dec #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned TOP_LSB = IDX_W + 2;

  logic upper_zero;

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_zero = (addr_i[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  // word aligned, inside the register window
  assign hit_o = upper_zero && (addr_i[1:0] == 2'b00);
  assign idx_o = addr_i[TOP_LSB-1:2];
endmodule

// File: rtl/cfg_field.sv
module cfg_field #(
  parameter int unsigned W      = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [W-1:0]      d_i,
  output logic [W-1:0]      q_o,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  generate
    if (W < DATA_W) begin : g_pad
      assign word_o = {{(DATA_W-W){1'b0}}, q_o};
    end else begin : g_full
      assign word_o = q_o;
    end
  endgenerate
endmodule

// File: rtl/apb_rd_mux.sv
module apb_rd_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N      = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N-1:0][DATA_W-1:0] words_i,
  input  logic [IDX_W-1:0]         sel_i,
  input  logic                     en_i,
  output logic [DATA_W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i && (sel_i == IDX_W'(i))) rdata_o = words_i[i];
    end
  end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 32,
  parameter int unsigned PULSE_W  = 32,
  parameter int unsigned SIZE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  output logic                pready_o,
  output logic [DATA_W-1:0]   prdata_o,
  output logic                pslverr_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [PULSE_W-1:0]  pulse_o,
  output logic [SIZE_W-1:0]   size_o,
  output logic                enable_o
);
  logic                            access, hit;
  logic [IDX_W-1:0]                idx;
  logic [NUM_REGS-1:0]             we;
  logic [NUM_REGS-1:0][DATA_W-1:0] words;

  assign access = psel_i && penable_i;

  apb_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr_i (paddr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      we[i] = access && pwrite_i && hit && (idx == IDX_W'(i));
  end

  cfg_field #(.W(PERIOD_W), .DATA_W(DATA_W)) u_period (
    .clk_i, .rst_ni, .we_i(we[REG_PERIOD]), .d_i(pwdata_i[PERIOD_W-1:0]),
    .q_o(period_o), .word_o(words[REG_PERIOD])
  );

  cfg_field #(.W(PULSE_W), .DATA_W(DATA_W)) u_pulse (
    .clk_i, .rst_ni, .we_i(we[REG_PULSE]), .d_i(pwdata_i[PULSE_W-1:0]),
    .q_o(pulse_o), .word_o(words[REG_PULSE])
  );

  cfg_field #(.W(SIZE_W), .DATA_W(DATA_W)) u_size (
    .clk_i, .rst_ni, .we_i(we[REG_SIZE]), .d_i(pwdata_i[SIZE_W-1:0]),
    .q_o(size_o), .word_o(words[REG_SIZE])
  );

  cfg_field #(.W(1), .DATA_W(DATA_W)) u_enable (
    .clk_i, .rst_ni, .we_i(we[REG_ENABLE]), .d_i(pwdata_i[0]),
    .q_o(enable_o), .word_o(words[REG_ENABLE])
  );

  apb_rd_mux #(.DATA_W(DATA_W), .N(NUM_REGS), .IDX_W(IDX_W)) u_rd (
    .words_i (words),
    .sel_i   (idx),
    .en_i    (access && !pwrite_i && hit),
    .rdata_o (prdata_o)
  );

  // zero wait states; error only for unmapped access
  assign pready_o  = access;
  assign pslverr_o = access && !hit;
endmodule

// File: rtl/pwm_cfg_regs_chk.sv
module pwm_cfg_regs_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 32,
  parameter int unsigned PULSE_W  = 32,
  parameter int unsigned SIZE_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   paddr_i,
  input logic                psel_i,
  input logic                penable_i,
  input logic                pwrite_i,
  input logic [DATA_W-1:0]   pwdata_i,
  input logic                pready_o,
  input logic [DATA_W-1:0]   prdata_o,
  input logic                pslverr_o,
  input logic [PERIOD_W-1:0] period_o,
  input logic [PULSE_W-1:0]  pulse_o,
  input logic [SIZE_W-1:0]   size_o,
  input logic                enable_o
);
  logic acc, mapped, wr_acc, rd_acc;
  assign acc    = psel_i && penable_i;
  assign mapped = (paddr_i[1:0] == 2'b00) && ((paddr_i >> 4) == '0);
  assign wr_acc = acc && pwrite_i;
  assign rd_acc = acc && !pwrite_i;

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (period_o == '0 && pulse_o == '0 && size_o == '0 && !enable_o));

  assert_period_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && mapped && paddr_i[3:2] == 2'd0) |=> period_o == $past(pwdata_i[PERIOD_W-1:0]));

  assert_pulse_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && mapped && paddr_i[3:2] == 2'd1) |=> pulse_o == $past(pwdata_i[PULSE_W-1:0]));

  assert_size_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && mapped && paddr_i[3:2] == 2'd2) |=> size_o == $past(pwdata_i[SIZE_W-1:0]));

  assert_size_rd_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && mapped && paddr_i[3:2] == 2'd2) |-> (prdata_o >> SIZE_W) == '0);

  assert_enable_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && mapped && paddr_i[3:2] == 2'd3) |=> enable_o == $past(pwdata_i[0]));

  assert_no_wr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_acc |=> ($stable(period_o) && $stable(pulse_o) && $stable(size_o) && $stable(enable_o)));

  assert_ready_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> pready_o);

  assert_ready_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !penable_i |-> !pready_o);

  assert_err_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> (pslverr_o == !mapped));

  assert_err_wr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && !mapped) |=> ($stable(period_o) && $stable(pulse_o) && $stable(size_o) && $stable(enable_o)));

  assert_err_rd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !mapped) |-> prdata_o == '0);

  assert_rdata_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |-> prdata_o == '0);
endmodule

bind pwm_cfg_regs pwm_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W),
  .PULSE_W(PULSE_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk_i, .rst_ni, .paddr_i, .psel_i, .penable_i, .pwrite_i, .pwdata_i,
  .pready_o, .prdata_o, .pslverr_o, .period_o, .pulse_o, .size_o, .enable_o
);

// File: tb/pwm_cfg_regs_bench.sv
module pwm_cfg_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [31:0] pwdata_i = '0;
  logic        pready_o, pslverr_o, enable_o;
  logic [31:0] prdata_o, period_o, pulse_o;
  logic [7:0]  size_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  pwm_cfg_regs u_pwm_cfg_regs (
    .clk_i, .rst_ni, .paddr_i, .psel_i, .penable_i, .pwrite_i, .pwdata_i,
    .pready_o, .prdata_o, .pslverr_o, .period_o, .pulse_o, .size_o, .enable_o
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'hDEADBEEF, 32'h0,        1'b0},
    '{1'b0, 8'h00, 32'h0,        32'hDEADBEEF, 1'b0},
    '{1'b1, 8'h04, 32'h12345678, 32'h0,        1'b0},
    '{1'b0, 8'h04, 32'h0,        32'h12345678, 1'b0},
    '{1'b1, 8'h08, 32'hFFFFFFA5, 32'h0,        1'b0},
    '{1'b0, 8'h08, 32'h0,        32'h000000A5, 1'b0},
    '{1'b1, 8'h0C, 32'hFFFFFFFF, 32'h0,        1'b0},
    '{1'b0, 8'h0C, 32'h0,        32'h00000001, 1'b0},
    '{1'b1, 8'h10, 32'h11111111, 32'h0,        1'b1},
    '{1'b0, 8'h10, 32'h0,        32'h0,        1'b1},
    '{1'b1, 8'h02, 32'h22222222, 32'h0,        1'b1},
    '{1'b0, 8'h00, 32'h0,        32'hDEADBEEF, 1'b0},
    '{1'b0, 8'h06, 32'h0,        32'h0,        1'b1},
    '{1'b1, 8'h08, 32'h00000000, 32'h0,        1'b0},
    '{1'b0, 8'h08, 32'h0,        32'h0,        1'b0}
  };

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00:   return "R2";
      8'h04:   return "R3";
      8'h08:   return "R4";
      8'h0C:   return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err, output logic rdy);
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = wr; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    penable_i = 1'b1;
    #1;
    rd = prdata_o; err = pslverr_o; rdy = pready_o;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        err, rdy;

    // R1: reset state
    #25;
    check("R1", period_o, 32'h0);
    check("R1", pulse_o, 32'h0);
    check("R1", {24'h0, size_o}, 32'h0);
    check("R1", {31'h0, enable_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R9", prdata_o, 32'h0);
    check("R7", {31'h0, pready_o}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, err, rdy);
      check("R7", {31'h0, rdy}, 32'h1);
      check(VECS[i].err ? "R8" : req_of(VECS[i].addr), {31'h0, err}, {31'h0, VECS[i].err});
      if (!VECS[i].wr) check(req_of(VECS[i].addr), rd, VECS[i].exp);
    end

    // outputs at the ports after the table
    check("R2", period_o, 32'hDEADBEEF);
    check("R3", pulse_o, 32'h12345678);
    check("R4", {24'h0, size_o}, 32'h0);
    check("R5", {31'h0, enable_o}, 32'h1);

    // R6: setup-only write leaves period unchanged
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b1; paddr_i = 8'h00; pwdata_i = 32'h0;
    #1;
    check("R7", {31'h0, pready_o}, 32'h0);
    check("R8", {31'h0, pslverr_o}, 32'h0);
    @(negedge clk_i);
    psel_i = 1'b0; pwrite_i = 1'b0;
    check("R6", period_o, 32'hDEADBEEF);

    // R6: penable without psel leaves pulse unchanged
    @(negedge clk_i);
    penable_i = 1'b1; pwrite_i = 1'b1; paddr_i = 8'h04; pwdata_i = 32'h0;
    #1;
    check("R7", {31'h0, pready_o}, 32'h0);
    @(negedge clk_i);
    penable_i = 1'b0; pwrite_i = 1'b0;
    check("R6", pulse_o, 32'h12345678);

    // R9: setup cycle of a read drives no data
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b0; paddr_i = 8'h00;
    #1;
    check("R9", prdata_o, 32'h0);
    @(negedge clk_i);
    psel_i = 1'b0;

    // R9: a write access cycle drives no read data
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b1; pwrite_i = 1'b1; paddr_i = 8'h00; pwdata_i = 32'h0000CAFE;
    #1;
    check("R9", prdata_o, 32'h0);
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
    check("R2", period_o, 32'h0000CAFE);

    // R1: reset mid-run clears every register
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", period_o, 32'h0);
    check("R1", pulse_o, 32'h0);
    check("R1", {31'h0, enable_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    xfer(1'b0, 8'h04, 32'h0, rd, err, rdy);
    check("R1", rd, 32'h0);

    finish_run();
  end
endmodule